// File: doc/BRIEF.md
# Banked Control Register File

This block holds the processor's control registers next to the general register file. A control-register index selects an entry on an asynchronous read port and on a synchronous write port. The block packs a status word out of a current status byte, a backup status byte and a separate condition bit. It keeps the backup and second-level backup program counters, a second-level backup status byte and two scratch words.

The block also owns the live stack-pointer general register, which is register 15 of the architectural file. The general register file reaches it through a single write port (`gpr_sp_we` / `gpr_sp_wdata`) and reads it on `sp_live`. Bit 7 of the current status byte is the stack-mode bit. The interrupt and user stack pointers are banked on that bit. One bank always lives in the general register and the other is parked in a slot of its own. A status write that flips the mode parks the live value and loads the other slot in the same clock edge.

Top module: `ctrl_reg_bank`

## Requirements
- R1: Reading index 0 returns the status word. Bits 15:8 hold the backup status byte ANDed with 0xC1, bits 7:6 hold bits 7:6 of the current status byte, bit 0 holds the condition bit, and every other bit is 0.
- R2: Writing index 0 loads the backup status byte from data bits 15:8 and the current status byte from bits 7:0. It also sets the condition bit from bit 0.
- R3: A status write that clears a stack-mode bit that was 1 stores the old live stack pointer in the user slot and moves the interrupt slot into the live stack pointer.
- R4: A status write that sets a stack-mode bit that was 0 stores the old live stack pointer in the interrupt slot and moves the user slot into the live stack pointer.
- R5: Index 2 reads as the condition bit in bit 0, with all other bits 0. Writing index 2 changes only the condition bit, taking it from data bit 0.
- R6: Index 3 is the interrupt stack pointer and index 6 is the user stack pointer. The interrupt index reaches the live stack pointer when the stack-mode bit is 0 and its own slot when it is 1. The user index does the reverse. This holds for both reads and writes.
- R7: Index 8 (backup PC) and index 9 (second-level backup PC) store all 32 write bits but always read with bit 0 equal to 0.
- R8: Index 1, the second-level backup status, is written from data bits 7:0 and reads as that byte ANDed with 0xC1.
- R9: Indices 4 and 5 are plain 32-bit scratch registers. Indices 7 and 10 to 15 read 0, and writes to them change no register.
- R10: Writes take effect at the rising clock edge when `cr_we` is high, and reads are combinational. A synchronous active-high reset clears every register, including the condition bit and the live stack pointer.
- R11: When a control-register write targets the live stack pointer, by a swap or by a banked index, in the same cycle as a general-register write to it, the control-register value wins.
- R12: A general-register write with no competing control-register write loads `sp_live` at the next edge. A status write that leaves the stack-mode bit unchanged moves no stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cr_ridx | input | 4 | Control-register read index |
| cr_rdata | output | 32 | Combinational read data |
| cr_we | input | 1 | Control-register write enable |
| cr_widx | input | 4 | Control-register write index |
| cr_wdata | input | 32 | Control-register write data |
| gpr_sp_we | input | 1 | General register file write to the stack pointer |
| gpr_sp_wdata | input | 32 | General register file stack-pointer write data |
| sp_live | output | 32 | Current value of the live stack-pointer register |

## Verification
A wrong parked stack-pointer slot stays hidden while the stack mode is steady, except through the banked index that selects it. It appears on `sp_live` one edge after the next mode-flipping status write. The bench therefore flips the mode in both directions after loading distinct values into both banks, and it reads both banked indices before and after each flip. A stale condition bit or status byte shows up at once on a combinational read of index 0 or 2. The bench reads these after writes that touch only one of the fields. A bad bit-0 mask or a leak from an unlisted index shows up on the very next read of that index.

// File: rtl/crf_pkg.sv
package crf_pkg;
    localparam int XLEN   = 32;
    localparam int IDX_W  = 4;
    localparam int N_SCR  = 2;

    localparam logic [IDX_W-1:0] IDX_STAT   = 4'd0;
    localparam logic [IDX_W-1:0] IDX_BBSTAT = 4'd1;
    localparam logic [IDX_W-1:0] IDX_COND   = 4'd2;
    localparam logic [IDX_W-1:0] IDX_ISP    = 4'd3;
    localparam logic [IDX_W-1:0] IDX_SCR0   = 4'd4;
    localparam logic [IDX_W-1:0] IDX_USP    = 4'd6;
    localparam logic [IDX_W-1:0] IDX_BPC    = 4'd8;
    localparam logic [IDX_W-1:0] IDX_BBPC   = 4'd9;

    localparam logic [7:0] BKP_MASK = 8'hC1;
    localparam logic [7:0] CUR_MASK = 8'hC0;
    localparam int         SM_BIT   = 7;

    typedef struct packed {
        logic [7:0]                 cur_stat;
        logic [7:0]                 bkp_stat;
        logic [7:0]                 bbk_stat;
        logic                       cond;
        logic [XLEN-1:0]            sp;
        logic [XLEN-1:0]            isp;
        logic [XLEN-1:0]            usp;
        logic [XLEN-1:0]            bpc;
        logic [XLEN-1:0]            bbpc;
        logic [N_SCR-1:0][XLEN-1:0] scr;
    } crf_state_t;
endpackage

// File: rtl/crf_status_pack.sv
module crf_status_pack
    import crf_pkg::*;
(
    input  logic [7:0]      cur_stat,
    input  logic [7:0]      bkp_stat,
    input  logic [7:0]      bbk_stat,
    input  logic            cond,
    output logic [XLEN-1:0] stat_word,
    output logic [XLEN-1:0] bbk_word,
    output logic [XLEN-1:0] cond_word
);
    localparam int PAD_HI = XLEN - 16;

    always_comb begin
        stat_word = {{PAD_HI{1'b0}}, bkp_stat & BKP_MASK,
                     (cur_stat & CUR_MASK) | {7'b0, cond}};
        bbk_word  = {{(XLEN-8){1'b0}}, bbk_stat & BKP_MASK};
        cond_word = {{(XLEN-1){1'b0}}, cond};
    end
endmodule

// File: rtl/crf_sp_bank.sv
module crf_sp_bank
    import crf_pkg::*;
(
    input  logic            sm_q,
    input  logic [XLEN-1:0] sp_q,
    input  logic [XLEN-1:0] isp_q,
    input  logic [XLEN-1:0] usp_q,
    input  logic            stat_wr,
    input  logic            new_sm,
    input  logic            isp_wr,
    input  logic            usp_wr,
    input  logic [XLEN-1:0] wdata,
    input  logic            gpr_we,
    input  logic [XLEN-1:0] gpr_wdata,
    output logic [XLEN-1:0] sp_d,
    output logic [XLEN-1:0] isp_d,
    output logic [XLEN-1:0] usp_d,
    output logic [XLEN-1:0] isp_rd,
    output logic [XLEN-1:0] usp_rd
);
    always_comb begin
        sp_d  = sp_q;
        isp_d = isp_q;
        usp_d = usp_q;
        // lowest priority: general register file port
        if (gpr_we) begin
            sp_d = gpr_wdata;
        end
        // stack-mode flip parks the live value and loads the other bank
        if (stat_wr && (new_sm != sm_q)) begin
            if (sm_q) begin
                usp_d = sp_q;
                sp_d  = isp_q;
            end else begin
                isp_d = sp_q;
                sp_d  = usp_q;
            end
        end
        if (isp_wr) begin
            if (!sm_q) sp_d  = wdata;
            else       isp_d = wdata;
        end
        if (usp_wr) begin
            if (sm_q)  sp_d  = wdata;
            else       usp_d = wdata;
        end
    end

    always_comb begin
        isp_rd = sm_q ? isp_q : sp_q;
        usp_rd = sm_q ? sp_q  : usp_q;
    end
endmodule

// File: rtl/ctrl_reg_bank.sv
module ctrl_reg_bank
    import crf_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int IDX_WIDTH = IDX_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_WIDTH-1:0] cr_ridx,
    output logic [DATA_W-1:0]    cr_rdata,
    input  logic                 cr_we,
    input  logic [IDX_WIDTH-1:0] cr_widx,
    input  logic [DATA_W-1:0]    cr_wdata,
    input  logic                 gpr_sp_we,
    input  logic [DATA_W-1:0]    gpr_sp_wdata,
    output logic [DATA_W-1:0]    sp_live
);
    localparam logic [DATA_W-1:0] LSB_CLR = {{(DATA_W-1){1'b1}}, 1'b0};

    crf_state_t state_q, state_d;

    logic            sm_q;
    logic            stat_wr, isp_wr, usp_wr;
    logic [XLEN-1:0] sp_n, isp_n, usp_n, isp_rd, usp_rd;
    logic [XLEN-1:0] stat_word, bbk_word, cond_word;
    logic [N_SCR-1:0] scr_wsel, scr_rsel;
    logic [XLEN-1:0] scr_rdata;

    assign sm_q    = state_q.cur_stat[SM_BIT];
    assign stat_wr = cr_we && (cr_widx == IDX_STAT);
    assign isp_wr  = cr_we && (cr_widx == IDX_ISP);
    assign usp_wr  = cr_we && (cr_widx == IDX_USP);

    crf_status_pack u_pack (
        .cur_stat (state_q.cur_stat),
        .bkp_stat (state_q.bkp_stat),
        .bbk_stat (state_q.bbk_stat),
        .cond     (state_q.cond),
        .stat_word(stat_word),
        .bbk_word (bbk_word),
        .cond_word(cond_word)
    );

    crf_sp_bank u_spbank (
        .sm_q     (sm_q),
        .sp_q     (state_q.sp),
        .isp_q    (state_q.isp),
        .usp_q    (state_q.usp),
        .stat_wr  (stat_wr),
        .new_sm   (cr_wdata[SM_BIT]),
        .isp_wr   (isp_wr),
        .usp_wr   (usp_wr),
        .wdata    (cr_wdata),
        .gpr_we   (gpr_sp_we),
        .gpr_wdata(gpr_sp_wdata),
        .sp_d     (sp_n),
        .isp_d    (isp_n),
        .usp_d    (usp_n),
        .isp_rd   (isp_rd),
        .usp_rd   (usp_rd)
    );

    // scratch decode, one select per slot
    for (genvar g = 0; g < N_SCR; g++) begin : g_scr
        localparam logic [IDX_WIDTH-1:0] MY_IDX = IDX_SCR0 + IDX_WIDTH'(g);
        assign scr_wsel[g] = cr_we && (cr_widx == MY_IDX);
        assign scr_rsel[g] = (cr_ridx == MY_IDX);
    end

    always_comb begin
        scr_rdata = '0;
        for (int k = 0; k < N_SCR; k++) begin
            if (scr_rsel[k]) scr_rdata = state_q.scr[k];
        end
    end

    // next-state process
    always_comb begin
        state_d     = state_q;
        state_d.sp  = sp_n;
        state_d.isp = isp_n;
        state_d.usp = usp_n;
        if (stat_wr) begin
            state_d.bkp_stat = cr_wdata[15:8];
            state_d.cur_stat = cr_wdata[7:0];
            state_d.cond     = cr_wdata[0];
        end
        if (cr_we) begin
            unique case (cr_widx)
                IDX_BBSTAT: state_d.bbk_stat = cr_wdata[7:0];
                IDX_COND:   state_d.cond     = cr_wdata[0];
                IDX_BPC:    state_d.bpc      = cr_wdata;
                IDX_BBPC:   state_d.bbpc     = cr_wdata;
                default:    ;
            endcase
        end
        for (int k = 0; k < N_SCR; k++) begin
            if (scr_wsel[k]) state_d.scr[k] = cr_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    // read mux
    always_comb begin
        unique case (cr_ridx)
            IDX_STAT:   cr_rdata = stat_word;
            IDX_BBSTAT: cr_rdata = bbk_word;
            IDX_COND:   cr_rdata = cond_word;
            IDX_ISP:    cr_rdata = isp_rd;
            IDX_USP:    cr_rdata = usp_rd;
            IDX_BPC:    cr_rdata = state_q.bpc & LSB_CLR;
            IDX_BBPC:   cr_rdata = state_q.bbpc & LSB_CLR;
            default:    cr_rdata = |scr_rsel ? scr_rdata : '0;
        endcase
    end

    assign sp_live = state_q.sp;
endmodule

// File: rtl/crf_checker.sv
module crf_checker
    import crf_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cr_we,
    input logic [IDX_W-1:0] cr_widx,
    input logic [XLEN-1:0] cr_wdata,
    input logic [IDX_W-1:0] cr_ridx,
    input logic [XLEN-1:0] cr_rdata,
    input logic            gpr_sp_we,
    input logic [XLEN-1:0] gpr_sp_wdata,
    input logic [XLEN-1:0] sp_live,
    input logic [7:0]      cur_q,
    input logic [7:0]      bkp_q,
    input logic            cond_q,
    input logic [XLEN-1:0] isp_q,
    input logic [XLEN-1:0] usp_q
);
    // R3 swap when the stack-mode bit falls
    a_r3_swap_down: assert property (@(posedge clk) disable iff (rst)
        (cr_we && cr_widx == IDX_STAT && cur_q[SM_BIT] && !cr_wdata[SM_BIT])
        |=> (sp_live == $past(isp_q)) && (usp_q == $past(sp_live)));

    // R4 swap when the stack-mode bit rises
    a_r4_swap_up: assert property (@(posedge clk) disable iff (rst)
        (cr_we && cr_widx == IDX_STAT && !cur_q[SM_BIT] && cr_wdata[SM_BIT])
        |=> (sp_live == $past(usp_q)) && (isp_q == $past(sp_live)));

    // R5 condition write leaves the status bytes alone
    a_r5_cond_only: assert property (@(posedge clk) disable iff (rst)
        (cr_we && cr_widx == IDX_COND)
        |=> $stable(cur_q) && $stable(bkp_q) && (cond_q == $past(cr_wdata[0])));

    // R7 backup PCs read with bit 0 cleared
    a_r7_pc_lsb: assert property (@(posedge clk) disable iff (rst)
        (cr_ridx == IDX_BPC || cr_ridx == IDX_BBPC) |-> !cr_rdata[0]);

    // R9 unlisted indices read zero
    a_r9_unlisted_zero: assert property (@(posedge clk) disable iff (rst)
        (cr_ridx == 4'd7 || cr_ridx >= 4'd10) |-> (cr_rdata == '0));

    // R11 banked write to the live pointer beats the general register port
    a_r11_cr_wins: assert property (@(posedge clk) disable iff (rst)
        (gpr_sp_we && cr_we && cr_widx == IDX_ISP && !cur_q[SM_BIT])
        |=> (sp_live == $past(cr_wdata)));

    // R12 uncontested general register write lands in the live pointer
    a_r12_gpr_write: assert property (@(posedge clk) disable iff (rst)
        (gpr_sp_we && !cr_we) |=> (sp_live == $past(gpr_sp_wdata)));
endmodule

bind ctrl_reg_bank crf_checker u_crf_chk (
    .clk         (clk),
    .rst         (rst),
    .cr_we       (cr_we),
    .cr_widx     (cr_widx),
    .cr_wdata    (cr_wdata),
    .cr_ridx     (cr_ridx),
    .cr_rdata    (cr_rdata),
    .gpr_sp_we   (gpr_sp_we),
    .gpr_sp_wdata(gpr_sp_wdata),
    .sp_live     (sp_live),
    .cur_q       (state_q.cur_stat),
    .bkp_q       (state_q.bkp_stat),
    .cond_q      (state_q.cond),
    .isp_q       (state_q.isp),
    .usp_q       (state_q.usp)
);

// File: tb/ctrl_reg_bank_tb.sv
`timescale 1ns/1ps
module ctrl_reg_bank_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  cr_ridx;
    logic [31:0] cr_rdata;
    logic        cr_we;
    logic [3:0]  cr_widx;
    logic [31:0] cr_wdata;
    logic        gpr_sp_we;
    logic [31:0] gpr_sp_wdata;
    logic [31:0] sp_live;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    ctrl_reg_bank dut_i (
        .clk(clk), .rst(rst), .cr_ridx(cr_ridx), .cr_rdata(cr_rdata),
        .cr_we(cr_we), .cr_widx(cr_widx), .cr_wdata(cr_wdata),
        .gpr_sp_we(gpr_sp_we), .gpr_sp_wdata(gpr_sp_wdata), .sp_live(sp_live)
    );

    // behavioural reference state
    logic [7:0]  m_cur, m_bkp, m_bbk;
    logic        m_cond;
    logic [31:0] m_sp, m_isp, m_usp, m_bpc, m_bbpc;
    logic [31:0] m_scr [2];

    task automatic model_reset();
        m_cur = 0; m_bkp = 0; m_bbk = 0; m_cond = 0;
        m_sp = 0; m_isp = 0; m_usp = 0; m_bpc = 0; m_bbpc = 0;
        m_scr[0] = 0; m_scr[1] = 0;
    endtask

    function automatic logic [31:0] model_read(int idx);
        bit sm = m_cur[7];
        case (idx)
            0: return {16'h0, m_bkp & 8'hC1, m_cur & 8'hC0} | {31'h0, m_cond};
            1: return {24'h0, m_bbk & 8'hC1};
            2: return {31'h0, m_cond};
            3: return sm ? m_isp : m_sp;
            4: return m_scr[0];
            5: return m_scr[1];
            6: return sm ? m_sp : m_usp;
            8: return {m_bpc[31:1], 1'b0};
            9: return {m_bbpc[31:1], 1'b0};
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_write(bit we, int idx, logic [31:0] wd, bit gwe, logic [31:0] gd);
        bit sm = m_cur[7];
        logic [31:0] old_sp = m_sp;
        if (gwe) m_sp = gd;
        if (!we) return;
        case (idx)
            0: begin
                if (sm && !wd[7]) begin m_usp = old_sp; m_sp = m_isp; end
                if (!sm && wd[7]) begin m_isp = old_sp; m_sp = m_usp; end
                m_bkp = wd[15:8]; m_cur = wd[7:0]; m_cond = wd[0];
            end
            1: m_bbk = wd[7:0];
            2: m_cond = wd[0];
            3: if (sm) m_isp = wd; else m_sp = wd;
            4: m_scr[0] = wd;
            5: m_scr[1] = wd;
            6: if (sm) m_sp = wd; else m_usp = wd;
            8: m_bpc = wd;
            9: m_bbpc = wd;
            default: ;
        endcase
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%08h expected=%08h at %0t", tag, act, exp, $time);
        end
    endtask

    // drive one cycle, compare outputs before the edge, then advance the model
    task automatic step(bit we, int widx, logic [31:0] wd, bit gwe, logic [31:0] gd,
                        int ridx, string tag);
        @(negedge clk);
        cr_we = we; cr_widx = 4'(widx); cr_wdata = wd;
        gpr_sp_we = gwe; gpr_sp_wdata = gd; cr_ridx = 4'(ridx);
        #1;
        chk({tag, " rdata"}, cr_rdata, model_read(ridx));
        chk({tag, " sp_live"}, sp_live, m_sp);
        @(posedge clk);
        model_write(we, widx, wd, gwe, gd);
    endtask

    task automatic sweep(string tag);
        for (int i = 0; i < 16; i++) step(0, 0, 0, 0, 0, i, tag);
    endtask

    initial begin
        rst = 1; cr_we = 0; cr_widx = 0; cr_wdata = 0;
        gpr_sp_we = 0; gpr_sp_wdata = 0; cr_ridx = 0;
        // dirty the state, then reset must clear it
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0; cr_we = 1; cr_widx = 4'd8; cr_wdata = 32'hFFFF_FFFF;
        gpr_sp_we = 1; gpr_sp_wdata = 32'h5555_5555;
        @(negedge clk); rst = 1; cr_we = 0; gpr_sp_we = 0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 0;
        model_reset();
        sweep("R10 reset");

        step(0, 0, 0, 1, 32'h1111_0000, 3, "R12 gpr write");
        step(1, 6, 32'h2222_0000, 0, 0, 3, "R6 usp slot write");
        step(0, 0, 0, 0, 0, 6, "R6 usp read sm0");
        step(1, 3, 32'h3333_0004, 1, 32'h9999_9999, 3, "R11 isp live vs gpr");
        step(0, 0, 0, 0, 0, 3, "R11 isp live");
        step(1, 0, 32'h0000_F3C5, 0, 0, 0, "R4 rise");
        step(0, 0, 0, 0, 0, 0, "R1 status pack");
        step(0, 0, 0, 0, 0, 3, "R4 isp slot");
        step(0, 0, 0, 0, 0, 6, "R6 usp live sm1");
        step(1, 3, 32'h4444_0008, 0, 0, 3, "R6 isp slot write sm1");
        step(1, 2, 32'hFFFF_FFFE, 0, 0, 0, "R5 cond clear");
        step(0, 0, 0, 0, 0, 2, "R5 cond read");
        step(0, 0, 0, 0, 0, 0, "R5 status after cond");
        step(1, 0, 32'h0000_3E80, 0, 0, 0, "R12 no swap");
        step(0, 0, 0, 0, 0, 3, "R12 isp kept");
        step(1, 6, 32'h6666_0010, 0, 0, 6, "R6 usp live write sm1");
        step(1, 0, 32'h0000_0041, 1, 32'h7777_7777, 0, "R3 fall vs gpr R11");
        step(0, 0, 0, 0, 0, 6, "R3 usp slot");
        step(1, 2, 32'h0000_0001, 0, 0, 2, "R5 cond set");
        step(1, 1, 32'h1234_56FF, 0, 0, 1, "R8 bbstat");
        step(1, 1, 32'h0000_003E, 0, 0, 1, "R8 bbstat mask");
        step(1, 8, 32'hDEAD_BEEF, 0, 0, 8, "R7 bpc");
        step(1, 9, 32'h1234_5679, 0, 0, 9, "R7 bbpc");
        step(1, 4, 32'hA5A5_0001, 0, 0, 4, "R9 scratch4");
        step(1, 5, 32'h5A5A_0003, 0, 0, 5, "R9 scratch5");
        step(1, 7,  32'hFFFF_FFFF, 0, 0, 7,  "R9 unlisted 7");
        step(1, 10, 32'hFFFF_FFFF, 0, 0, 10, "R9 unlisted 10");
        step(1, 15, 32'hFFFF_FFFF, 0, 0, 15, "R9 unlisted 15");
        sweep("R9 R10 sweep");

        for (int n = 0; n < 400; n++) begin
            int wi = $urandom_range(0, 15);
            int ri = $urandom_range(0, 15);
            logic [31:0] wd = $urandom;
            if (wi == 0 && ($urandom_range(0, 3) != 0)) wd[7] = m_cur[7];
            step($urandom_range(0, 1) == 1, wi, wd, $urandom_range(0, 2) == 0, $urandom,
                 ri, "R1 R2 R6 R11 random");
        end
        sweep("R2 R3 R4 final sweep");

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL R10 watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule